// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges five independent reset causes into a single reset for the digital logic and a separate, delayed reset for the processor. The causes are an active-low reset pin, an active-low emergency reset, a supply comparator reporting a supply below its threshold, a crystal-fault request, and a watchdog overflow pulse that may last only half a crystal-clock period. Every cause takes effect at once, without waiting for a clock edge. Each cause is then released through its own two-flop synchronizer on the crystal clock.

Once the digital reset has been released, the block keeps the processor in reset for a fixed startup delay. This is 4100 crystal-clock cycles by default. After the delay it raises a fetch-enable, and the processor begins executing from address zero. A cause that returns during the delay starts the delay again from zero. A small cause register keeps a record of which sources were active, so firmware can read it after startup. The oscillator and the real-time clock are outside this block and keep running through every reset.

Top module: `rst_sequencer`

## Requirements
- R1: Any one of the five sources drives `dig_rst_n` and `cpu_rst_n` low and `fetch_en` low at once, without waiting for a clock edge. The five sources are `pin_rst_n` low, `emerg_rst_n` low, `supply_low` high, `xtal_fault` high, and `wdt_ovf` high.
- R2: `dig_rst_n` returns high on the second rising clock edge after the last active source deasserts. It is still low after the first edge.
- R3: `io_clr` is high while the pin, supply-low or watchdog source is held. Emergency and crystal-fault sources, alone or together, leave `io_clr` low.
- R4: A `wdt_ovf` pulse shorter than one clock period produces a full reset. That reset holds `dig_rst_n` low through the first rising edge after the pulse, then sequences exactly like a pin reset released at the pulse's end.
- R5: `cpu_rst_n` and `fetch_en` stay low through reset and the startup delay. Both rise on the DELAY-th rising edge after the edge that released `dig_rst_n`. With the default DELAY of 4100, this is the 4102nd edge after the source deasserts.
- R6: A source asserted during the startup delay restarts the delay from zero. `fetch_en` then rises 4102 edges after that source deasserts.
- R7: `rst_cause` holds the set of sources active in the final held cycle of the most recent reset. The bits are 0 pin, 1 emergency, 2 supply-low, 3 crystal fault, 4 watchdog. The value stays unchanged until the next reset.
- R8: While no source is active, `dig_rst_n`, `cpu_rst_n` and `fetch_en` stay released indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| pin_rst_n | input | 1 | External reset pin, active low |
| emerg_rst_n | input | 1 | Emergency reset, active low |
| supply_low | input | 1 | Supply comparator below threshold |
| xtal_fault | input | 1 | Crystal malfunction request |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| dig_rst_n | output | 1 | Digital-domain reset, active low |
| io_clr | output | 1 | Clear for the I/O register bank |
| cpu_rst_n | output | 1 | Processor reset, active low |
| fetch_en | output | 1 | Start execution at address zero |
| rst_cause | output | 5 | Sources of the most recent reset |

## Verification
A stuck or mis-cleared synchronizer stage shows up at `dig_rst_n`. The port either fails to fall at once or releases one edge early or late, so it is visible within two cycles of a source changing. A wrong delay count or a missed restart moves the rise of `fetch_en` away from the 4102nd edge. That error only appears at the end of the delay, which is why every episode counts edges to that exact point. A wrong cause capture appears in `rst_cause` as soon as the processor starts.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int NUM_SRC = 5;

    localparam int SRC_PIN    = 0;
    localparam int SRC_EMERG  = 1;
    localparam int SRC_SUPPLY = 2;
    localparam int SRC_XTAL   = 3;
    localparam int SRC_WDT    = 4;

    // sources that also wipe the I/O register bank
    localparam logic [NUM_SRC-1:0] IO_CLR_MASK =
        (NUM_SRC'(1) << SRC_PIN) | (NUM_SRC'(1) << SRC_SUPPLY) | (NUM_SRC'(1) << SRC_WDT);

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rsq_sync.sv
// Asynchronous-assert, synchronous-release stage for one reset source.
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req,
    output logic held
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or posedge req) begin
        if (req) ff_q <= '1;
        else     ff_q <= {ff_q[STAGES-2:0], 1'b0};
    end

    assign held = ff_q[STAGES-1];
endmodule

// File: rtl/rsq_seq.sv
// Startup delay: counts DELAY edges after reset release, then runs.
module rsq_seq
    import rsq_pkg::*;
#(
    parameter int DELAY = 4100
) (
    input  logic clk,
    input  logic rst_any,
    output logic run
);
    localparam int CW = $clog2(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.st == ST_WAIT) begin
            if (s_q.cnt == LAST) begin
                s_d.st  = ST_RUN;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst_any) begin
        if (rst_any) s_q <= '{st: ST_WAIT, cnt: '0};
        else         s_q <= s_d;
    end

    assign run = (s_q.st == ST_RUN);
endmodule

// File: rtl/rsq_cause.sv
// Snapshot of held sources; frozen once all sources are released.
module rsq_cause
    import rsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_any,
    input  logic [NUM_SRC-1:0] held_vec,
    output logic [NUM_SRC-1:0] cause
);
    logic [NUM_SRC-1:0] cause_d, cause_q;

    always_comb begin
        cause_d = cause_q;
        if (rst_any) cause_d = held_vec;
    end

    always_ff @(posedge clk) begin
        cause_q <= cause_d;
    end

    assign cause = cause_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rsq_pkg::*;
#(
    parameter int DELAY       = 4100,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               pin_rst_n,
    input  logic               emerg_rst_n,
    input  logic               supply_low,
    input  logic               xtal_fault,
    input  logic               wdt_ovf,
    output logic               dig_rst_n,
    output logic               io_clr,
    output logic               cpu_rst_n,
    output logic               fetch_en,
    output logic [NUM_SRC-1:0] rst_cause
);
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] held;
    logic               rst_any;
    logic               run;

    always_comb begin
        req             = '0;
        req[SRC_PIN]    = ~pin_rst_n;
        req[SRC_EMERG]  = ~emerg_rst_n;
        req[SRC_SUPPLY] = supply_low;
        req[SRC_XTAL]   = xtal_fault;
        req[SRC_WDT]    = wdt_ovf;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .req  (req[i]),
            .held (held[i])
        );
    end

    assign rst_any = |held;

    rsq_seq #(.DELAY(DELAY)) u_seq (
        .clk     (clk),
        .rst_any (rst_any),
        .run     (run)
    );

    rsq_cause u_cause (
        .clk      (clk),
        .rst_any  (rst_any),
        .held_vec (held),
        .cause    (rst_cause)
    );

    assign dig_rst_n = ~rst_any;
    assign io_clr    = |(held & IO_CLR_MASK);
    assign fetch_en  = run;
    assign cpu_rst_n = run;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
    parameter int DELAY = 4100
) (
    input logic       clk,
    input logic       pin_rst_n,
    input logic       emerg_rst_n,
    input logic       wdt_ovf,
    input logic       dig_rst_n,
    input logic       io_clr,
    input logic       cpu_rst_n,
    input logic       fetch_en
);
    localparam int CW = $clog2(DELAY + 2);
    logic [CW-1:0] rel_cnt;

    always_ff @(posedge clk) begin
        if (!dig_rst_n)                  rel_cnt <= '0;
        else if (rel_cnt != CW'(DELAY + 1)) rel_cnt <= rel_cnt + 1'b1;
    end

    // R1
    emerg_resets_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        !emerg_rst_n |-> (!dig_rst_n && !fetch_en));

    // R3
    io_clr_in_reset_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        io_clr |-> !dig_rst_n);

    // R4
    wdt_stretch_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        wdt_ovf |=> !dig_rst_n);

    // R5
    start_delay_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $rose(fetch_en) |-> (rel_cnt == CW'(DELAY)));

    // R5
    cpu_follows_fetch_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        fetch_en == cpu_rst_n);

    // R8
    run_only_drops_on_reset_chk: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $fell(fetch_en) |-> !dig_rst_n);
endmodule

bind rst_sequencer rsq_chk #(.DELAY(DELAY)) u_chk (
    .clk         (clk),
    .pin_rst_n   (pin_rst_n),
    .emerg_rst_n (emerg_rst_n),
    .wdt_ovf     (wdt_ovf),
    .dig_rst_n   (dig_rst_n),
    .io_clr      (io_clr),
    .cpu_rst_n   (cpu_rst_n),
    .fetch_en    (fetch_en)
);

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/1ps
module tb_rst_sequencer;
    localparam int DELAY = 4100;

    logic       clk = 1'b0;
    logic       pin_rst_n = 1'b0;
    logic       emerg_rst_n = 1'b1;
    logic       supply_low = 1'b0;
    logic       xtal_fault = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       dig_rst_n, io_clr, cpu_rst_n, fetch_en;
    logic [4:0] rst_cause;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rst_sequencer #(.DELAY(DELAY)) dut (
        .clk(clk), .pin_rst_n(pin_rst_n), .emerg_rst_n(emerg_rst_n),
        .supply_low(supply_low), .xtal_fault(xtal_fault), .wdt_ovf(wdt_ovf),
        .dig_rst_n(dig_rst_n), .io_clr(io_clr), .cpu_rst_n(cpu_rst_n),
        .fetch_en(fetch_en), .rst_cause(rst_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [4:0] m);
        pin_rst_n   = ~m[0];
        emerg_rst_n = ~m[1];
        supply_low  = m[2];
        xtal_fault  = m[3];
        wdt_ovf     = m[4];
    endtask

    // after source release (at a negedge), check release timing, delay and cause
    task automatic after_release(input logic [4:0] cause_exp, input string tag);
        @(posedge clk); #2;
        chk(dig_rst_n == 1'b0, {tag, " R2 first edge"}, dig_rst_n, 0);
        @(posedge clk); #2;
        chk(dig_rst_n == 1'b1, {tag, " R2 second edge"}, dig_rst_n, 1);
        repeat (DELAY - 1) @(posedge clk);
        #2;
        chk(fetch_en == 1'b0, {tag, " R5 early"}, fetch_en, 0);
        @(posedge clk); #2;
        chk(fetch_en == 1'b1 && cpu_rst_n == 1'b1, {tag, " R5 start"}, fetch_en, 1);
        chk(rst_cause == cause_exp, {tag, " R7 cause"}, rst_cause, cause_exp);
    endtask

    task automatic episode(input logic [4:0] m);
        logic io_exp;
        io_exp = |(m & 5'b10101);
        @(negedge clk);
        drive(m);
        #1;
        chk(dig_rst_n == 1'b0 && fetch_en == 1'b0 && cpu_rst_n == 1'b0, "R1 immediate",
            dig_rst_n, 0);
        chk(io_clr == io_exp, "R3 io_clr", io_clr, io_exp);
        repeat (3) @(posedge clk);
        @(negedge clk);
        drive(5'b0);
        after_release(m, "sweep");
    endtask

    initial begin
        // reset state under the pin
        repeat (4) @(posedge clk);
        #2;
        chk(dig_rst_n == 1'b0 && cpu_rst_n == 1'b0 && fetch_en == 1'b0, "R1 reset state",
            dig_rst_n, 0);
        chk(io_clr == 1'b1, "R3 pin clears io", io_clr, 1);
        @(negedge clk);
        pin_rst_n = 1'b1;
        after_release(5'b00001, "start");

        // R8: idle, nothing released drops
        repeat (100) @(posedge clk);
        #2;
        chk(dig_rst_n && cpu_rst_n && fetch_en, "R8 idle stays released", fetch_en, 1);

        // R4: half-cycle watchdog pulse
        @(negedge clk);
        wdt_ovf = 1'b1;
        #1;
        chk(dig_rst_n == 1'b0 && io_clr == 1'b1, "R4 pulse takes effect", dig_rst_n, 0);
        #2;
        wdt_ovf = 1'b0;
        after_release(5'b10000, "R4 wdt");

        // R6: restart of the delay
        @(negedge clk);
        pin_rst_n = 1'b0;
        @(negedge clk);
        pin_rst_n = 1'b1;
        repeat (2000) @(posedge clk);
        @(negedge clk);
        emerg_rst_n = 1'b0;
        #1;
        chk(io_clr == 1'b0, "R3 emergency leaves io", io_clr, 0);
        @(negedge clk);
        emerg_rst_n = 1'b1;
        after_release(5'b00010, "R6 restart");

        // near-exhaustive sweep of source combinations
        for (int m = 1; m < 32; m++) episode(5'(m));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule